// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

A small word-addressed store in which every word has a presence tag beside its data. The tag says whether the word holds a value that nobody has consumed yet ("full") or a slot that is free for the next value ("empty"). A producer deposits a value with a *put*. A put succeeds only if the tag shows empty, and it then writes the word and sets the tag to full. A consumer removes a value with a *take*. A take succeeds only if the tag shows full, and it then returns the word and clears the tag to empty. The tag test, the tag change and the data access are one indivisible step. Each word can therefore serve as a one-slot handoff channel between a producer and a consumer.

Plain loads and plain stores exist alongside put and take. They read or write the data and never look at the tag or change it. A put or take whose tag condition is not met is refused. It changes nothing, and the requester tries again later. The block has one request port that accepts one request per clock. Every request gets a registered response on the next cycle. The response reports whether the request was granted, the data read, and the tag of the addressed word after the operation.

Top module: `fe_word_mem`

## Requirements
- R1: After reset every tag is empty and `rspValid` is low; a plain load of any word right after reset reports `rspFull` = 0.
- R2: A request sampled with `reqValid` high at a clock edge produces `rspValid` high for exactly the following cycle; a cycle without a request produces `rspValid` low on the next cycle.
- R3: A put (`reqOp` = 3'b100) to an empty word writes `reqData`, sets the tag to full and answers `rspOk` = 1, `rspFull` = 1.
- R4: A put to a full word answers `rspOk` = 0, `rspFull` = 1 and leaves both data and tag unchanged.
- R5: A take (`reqOp` = 3'b011) from a full word returns the stored data on `rspData`, clears the tag and answers `rspOk` = 1, `rspFull` = 0.
- R6: A take from an empty word answers `rspOk` = 0, `rspFull` = 0 and leaves data and tag unchanged.
- R7: A plain store (`reqOp` = 3'b010) always writes `reqData`, answers `rspOk` = 1 and leaves the tag as it was.
- R8: A plain load (`reqOp` = 3'b001) always returns the stored data, answers `rspOk` = 1 and leaves the tag as it was.
- R9: On every response, `rspFull` equals the tag of the addressed word after the request has taken effect.
- R10: The codes 3'b000, 3'b101, 3'b110 and 3'b111 are refused (`rspOk` = 0) and change neither data nor any tag.
- R11: A request in the cycle right after another request sees that request's effect on data and tag, including on the same address.
- R12: `rspData` is zero on every response that is not a granted load or take.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqOp | input | 3 | Operation: 001 load, 010 store, 011 take, 100 put, others refused |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | DATA_W | Write data for store and put |
| rspValid | output | 1 | Response for the request of the previous cycle |
| rspOk | output | 1 | Request granted (0: refused, retry) |
| rspData | output | DATA_W | Data read by a granted load or take, otherwise zero |
| rspFull | output | 1 | Tag of the addressed word after the operation |

## Verification
Each response is due one rising edge after its request. The bench drives a request at a falling edge and reads `rspValid`, `rspOk`, `rspFull` and `rspData` at the next falling edge, half a period after the edge that registered them. The next request goes out in the same falling-edge slot, so back-to-back requests test whether a request sees the state its predecessor left. An effect that only later requests can see is checked through the bench's word and tag model on later loads and takes. These include the unchanged data after a refused put.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

  localparam logic [2:0] OP_LOAD  = 3'b001;
  localparam logic [2:0] OP_STORE = 3'b010;
  localparam logic [2:0] OP_TAKE  = 3'b011;
  localparam logic [2:0] OP_PUT   = 3'b100;

  // strobes from control to datapath for the current request
  typedef struct packed {
    logic respond;    // a response is due next cycle
    logic grant;      // request accepted
    logic writeWord;  // write reqData into the addressed word
    logic readWord;   // return the addressed word
    logic setFull;    // mark the addressed word full
    logic clrFull;    // mark the addressed word empty
  } strobe_t;

endpackage

// File: rtl/fe_mem_ctrl.sv
module fe_mem_ctrl
  import fe_mem_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       tagAtAddr,
  output strobe_t    strobes
);

  always_comb begin
    strobes = '0;
    strobes.respond = reqValid;
    if (reqValid) begin
      case (reqOp)
        OP_LOAD: begin
          strobes.grant    = 1'b1;
          strobes.readWord = 1'b1;
        end
        OP_STORE: begin
          strobes.grant     = 1'b1;
          strobes.writeWord = 1'b1;
        end
        OP_TAKE: begin
          if (tagAtAddr) begin
            strobes.grant    = 1'b1;
            strobes.readWord = 1'b1;
            strobes.clrFull  = 1'b1;
          end
        end
        OP_PUT: begin
          if (!tagAtAddr) begin
            strobes.grant     = 1'b1;
            strobes.writeWord = 1'b1;
            strobes.setFull   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fe_mem_dpath.sv
module fe_mem_dpath
  import fe_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              tagAtAddr,
  output logic              rspValid,
  output logic              rspOk,
  output logic [DATA_W-1:0] rspData,
  output logic              rspFull
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];
  logic [DEPTH-1:0]  fullBits;
  logic              tagNext;

  assign tagAtAddr = fullBits[reqAddr];
  assign tagNext   = strobes.setFull ? 1'b1 :
                     strobes.clrFull ? 1'b0 : tagAtAddr;

  // data storage, no reset
  always_ff @(posedge clk) begin
    if (strobes.writeWord) words[reqAddr] <= reqData;
  end

  // one presence tag per word
  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fullBits[g] <= 1'b0;
      end else if (reqAddr == ADDR_W'(g)) begin
        if (strobes.setFull)      fullBits[g] <= 1'b1;
        else if (strobes.clrFull) fullBits[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspOk    <= 1'b0;
      rspData  <= '0;
      rspFull  <= 1'b0;
    end else begin
      rspValid <= strobes.respond;
      rspOk    <= strobes.grant;
      rspData  <= strobes.readWord ? words[reqAddr] : '0;
      rspFull  <= strobes.respond ? tagNext : 1'b0;
    end
  end

endmodule

// File: rtl/fe_word_mem.sv
module fe_word_mem
  import fe_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  output logic              rspOk,
  output logic [DATA_W-1:0] rspData,
  output logic              rspFull
);

  strobe_t strobes;
  logic    tagAtAddr;

  fe_mem_ctrl u_ctrl (
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .tagAtAddr (tagAtAddr),
    .strobes   (strobes)
  );

  fe_mem_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .tagAtAddr (tagAtAddr),
    .rspValid  (rspValid),
    .rspOk     (rspOk),
    .rspData   (rspData),
    .rspFull   (rspFull)
  );

endmodule

// File: rtl/fe_mem_chk.sv
module fe_mem_chk
  import fe_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqData,
  input logic              rspValid,
  input logic              rspOk,
  input logic [DATA_W-1:0] rspData,
  input logic              rspFull
);

  logic isReserved;
  assign isReserved = !(reqOp inside {OP_LOAD, OP_STORE, OP_TAKE, OP_PUT});

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_put_marks_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_PUT) |=> (!rspOk || rspFull));

  assert_refused_put_sees_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_PUT) |=> (rspOk || rspFull));

  assert_take_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_TAKE) |=> !rspFull);

  assert_plain_granted_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqOp == OP_LOAD || reqOp == OP_STORE)) |=> rspOk);

  assert_reserved_refused_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isReserved) |=> (!rspOk && rspData == '0));

  assert_ok_needs_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspOk |-> rspValid);

  // a take right after a granted put to the same word must succeed
  assert_put_then_take_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_TAKE && rspValid && rspOk && rspFull &&
     $past(reqValid) && $past(reqOp) == OP_PUT && $past(reqAddr) == reqAddr)
    |=> rspOk);

  assert_data_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspOk) |-> rspData == '0);

endmodule

bind fe_word_mem fe_mem_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fe_word_mem_tb.sv
`timescale 1ns/1ps
module fe_word_mem_tb;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          rspValid, rspOk, rspFull;
  logic [DW-1:0] rspData;

  always #4 clk = ~clk;

  fe_word_mem #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid),
    .rspOk(rspOk), .rspData(rspData), .rspFull(rspFull));

  logic [DW-1:0] mdlWord [NW];
  bit            mdlFull [NW];
  bit            mdlKnown[NW];
  int checks = 0;
  int errors = 0;

  task automatic check(input bit good, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [2:0] op, input bit full);
    case (op)
      3'b001: return "R8";
      3'b010: return "R7";
      3'b011: return full ? "R5" : "R6";
      3'b100: return full ? "R4" : "R3";
      default: return "R10";
    endcase
  endfunction

  // issue one request at a falling edge, check its response one edge later
  task automatic doOp(input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    bit expOk, expFull, dataKnown;
    logic [DW-1:0] expData;
    string req;
    req = reqOf(op, mdlFull[a]);
    expOk = 1'b0; expFull = mdlFull[a]; expData = '0; dataKnown = 1'b1;
    case (op)
      3'b001: begin expOk = 1; expData = mdlWord[a]; dataKnown = mdlKnown[a]; end
      3'b010: expOk = 1;
      3'b011: if (mdlFull[a]) begin
                expOk = 1; expData = mdlWord[a]; dataKnown = mdlKnown[a]; expFull = 0;
              end
      3'b100: if (!mdlFull[a]) begin expOk = 1; expFull = 1; end
      default: ;
    endcase
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1, "R2", {tag, " rspValid"}, DW'(rspValid), 1);
    check(rspOk == expOk, req, {tag, " rspOk"}, DW'(rspOk), DW'(expOk));
    check(rspFull == expFull, "R9", {tag, " rspFull"}, DW'(rspFull), DW'(expFull));
    if (dataKnown)
      check(rspData == expData, expOk ? req : "R12", {tag, " rspData"}, rspData, expData);
    if ((op == 3'b010) || (op == 3'b100 && expOk)) begin
      mdlWord[a] = d; mdlKnown[a] = 1'b1;
    end
    mdlFull[a] = expFull;
  endtask

  task automatic idle();
    reqValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(rspValid == 1'b0, "R2", "idle rspValid", DW'(rspValid), 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      mdlWord[i] = '0; mdlFull[i] = 0; mdlKnown[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, "R1", "rspValid in reset", DW'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R1", "rspValid after reset", DW'(rspValid), 0);

    // R1: all tags empty after reset
    for (int i = 0; i < NW; i++) doOp(3'b001, AW'(i), '0, "R1 tag after reset");
    // R7: fill every word with a plain store
    for (int i = 0; i < NW; i++) doOp(3'b010, AW'(i), DW'(32'hA500_0000 + i), "R7 fill");

    doOp(3'b100, 4'd3, 32'h1111_2222, "R3 put empty");
    doOp(3'b100, 4'd3, 32'hDEAD_BEEF, "R4 put full");
    doOp(3'b001, 4'd3, '0, "R8 load keeps full");
    doOp(3'b011, 4'd3, '0, "R5 take full");
    doOp(3'b011, 4'd3, '0, "R6 take empty");
    doOp(3'b001, 4'd3, '0, "R6 load keeps empty");
    doOp(3'b100, 4'd5, 32'h0000_0055, "R3 put");
    doOp(3'b010, 4'd5, 32'h0000_0077, "R7 store on full");
    doOp(3'b011, 4'd5, '0, "R7 take after store");
    for (int op = 0; op < 8; op++)
      if (!(op inside {1, 2, 3, 4})) doOp(3'(op), 4'd5, 32'hFFFF_FFFF, "R10 reserved empty");
    doOp(3'b100, 4'd6, 32'h0000_0066, "R3 put");
    for (int op = 0; op < 8; op++)
      if (!(op inside {1, 2, 3, 4})) doOp(3'(op), 4'd6, 32'hFFFF_FFFF, "R10 reserved full");
    doOp(3'b011, 4'd6, '0, "R10 data intact");
    idle();
    // R11: back-to-back on one word
    doOp(3'b100, 4'd9, 32'h9999_0001, "R11 put");
    doOp(3'b011, 4'd9, '0, "R11 take");
    doOp(3'b100, 4'd9, 32'h9999_0002, "R11 put again");
    doOp(3'b100, 4'd9, 32'h9999_0003, "R11 put refused");
    doOp(3'b011, 4'd9, '0, "R11 take again");
    idle();

    // constrained random traffic with a fixed seed
    void'($urandom(32'd20240611));
    for (int n = 0; n < 1500; n++) begin
      int pick;
      logic [2:0] op;
      pick = int'($urandom % 16);
      if (pick == 0) idle();
      else begin
        if (pick < 4) op = 3'b011;
        else if (pick < 7) op = 3'b100;
        else if (pick < 10) op = 3'b001;
        else if (pick < 14) op = 3'b010;
        else op = 3'(($urandom % 4) == 0 ? 0 : 5 + ($urandom % 3));
        doOp(op, AW'($urandom % 4), $urandom, "random");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule